// File: doc/BRIEF.md
# Registered Two-Source Integer ALU

This block is the arithmetic and logic unit of a small load/store processor core. Each cycle it takes two data sources, a shift distance and an operation code, and produces a single result. From that result it also derives a flag that reports an all-zero value. Every operation reads exactly two sources and writes one destination. The result and the flag are registered, so a value appears one clock after its inputs are sampled.

Constants from the instruction stream enter through a separate 16-bit immediate input. When the immediate select is high, the immediate is sign-extended and replaces the second source. There is no separate operation for subtracting a constant, so a negative immediate fed to the add operation does that job.

Bitwise inversion has no operation of its own. It comes from the NOR operation with a zero second source.

Top module: `alu_core`

## Requirements
- R1: Operation code 0 (add) returns src_a plus the second source, wrapped modulo 2^32, with no overflow indication.
- R2: Operation code 1 (subtract) returns src_a plus the inverted second source plus 1, wrapped modulo 2^32.
- R3: Operation code 2 returns the bitwise AND of the two sources, and operation code 3 returns their bitwise OR.
- R4: Operation code 4 returns the inversion of (src_a OR second source). With a zero second source this gives the bitwise NOT of src_a.
- R5: Operation code 5 shifts src_a left by shamt and fills the vacated low bits with 0. src_b is ignored.
- R6: Operation code 6 shifts src_a right by shamt and fills the vacated high bits with 0. src_b is ignored.
- R7: When use_imm is 1, the second source is imm16 with bit 15 copied into bits 31..16. When use_imm is 0, the second source is src_b.
- R8: Operation codes 7 through 15 return a result of 0.
- R9: zero is 1 exactly when all 32 bits of result are 0.
- R10: result and zero update one clock edge after their inputs are sampled. A synchronous active-high rst sets result to 0 and zero to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 4 | Operation code |
| src_a | input | 32 | First source |
| src_b | input | 32 | Second source register value |
| imm16 | input | 16 | Signed immediate constant |
| use_imm | input | 1 | Use the sign-extended immediate as second source |
| shamt | input | 5 | Shift distance |
| result | output | 32 | Registered result |
| zero | output | 1 | Registered all-zero flag |

## Verification
The block holds no state beyond its output registers, so any fault in the datapath appears at result on the very next cycle. Example faults are a wrong carry-in, a missing sign copy or a shift stage with the wrong weight. The vectors are chosen so that each of these produces a wrong value. Operand patterns differ between halves, carry across all 32 bits, and use shift distances of 4 and 31. Immediates sit on both sides of bit 15. A flag register that drifts from the result register is caught in the same cycle by comparing the flag against the observed result.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned OP_W = 4;
  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_NOR = 4'd4,
    OP_SLL = 4'd5,
    OP_SRL = 4'd6
  } alu_op_e;
endpackage

// File: rtl/alu_sext.sv
module alu_sext #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned OUT_W = 32
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam int unsigned FILL_W = OUT_W - IN_W;
  assign dout = {{FILL_W{din[IN_W-1]}}, din};
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] sum
);
  logic [DW-1:0] b_op;
  assign b_op = sub ? ~b : b;
  assign sum  = a + b_op + DW'(sub);
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] and_o,
  output logic [DW-1:0] or_o,
  output logic [DW-1:0] nor_o
);
  assign and_o = a & b;
  assign or_o  = a | b;
  assign nor_o = ~or_o;
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int unsigned DW  = 32,
  parameter int unsigned SHW = 5
) (
  input  logic [DW-1:0]  din,
  input  logic [SHW-1:0] amt,
  input  logic           right,
  output logic [DW-1:0]  dout
);
  logic [DW-1:0] rev_in;
  logic [DW-1:0] stg [0:SHW];

  for (genvar i = 0; i < DW; i++) begin : g_rev_in
    assign rev_in[i] = right ? din[DW-1-i] : din[i];
  end

  assign stg[0] = rev_in;
  for (genvar k = 0; k < SHW; k++) begin : g_stage
    assign stg[k+1] = amt[k] ? (stg[k] << (2**k)) : stg[k];
  end

  for (genvar j = 0; j < DW; j++) begin : g_rev_out
    assign dout[j] = right ? stg[SHW][DW-1-j] : stg[SHW][j];
  end
endmodule

// File: rtl/alu_core.sv
module alu_core #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IMM_W   = 16,
  parameter int unsigned SHAMT_W = $clog2(DATA_W)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [3:0]           op_sel,
  input  logic [DATA_W-1:0]    src_a,
  input  logic [DATA_W-1:0]    src_b,
  input  logic [IMM_W-1:0]     imm16,
  input  logic                 use_imm,
  input  logic [SHAMT_W-1:0]   shamt,
  output logic [DATA_W-1:0]    result,
  output logic                 zero
);
  import alu_pkg::*;

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] imm_ext, opb, sum, and_v, or_v, nor_v, shl_v, shr_v, res_nxt;
  alu_op_e op_e;

  assign op_e = alu_op_e'(op_sel);

  alu_sext #(.IN_W(IMM_W), .OUT_W(DATA_W)) u_sext (.din(imm16), .dout(imm_ext));

  assign opb = use_imm ? imm_ext : src_b;

  alu_addsub #(.DW(DATA_W)) u_addsub (
    .a(src_a), .b(opb), .sub(op_e == OP_SUB), .sum(sum));

  alu_logic #(.DW(DATA_W)) u_logic (
    .a(src_a), .b(opb), .and_o(and_v), .or_o(or_v), .nor_o(nor_v));

  alu_shift #(.DW(DATA_W), .SHW(SHAMT_W)) u_shl (
    .din(src_a), .amt(shamt), .right(1'b0), .dout(shl_v));

  alu_shift #(.DW(DATA_W), .SHW(SHAMT_W)) u_shr (
    .din(src_a), .amt(shamt), .right(1'b1), .dout(shr_v));

  always_comb begin
    case (op_e)
      OP_ADD, OP_SUB: res_nxt = sum;
      OP_AND:         res_nxt = and_v;
      OP_OR:          res_nxt = or_v;
      OP_NOR:         res_nxt = nor_v;
      OP_SLL:         res_nxt = shl_v;
      OP_SRL:         res_nxt = shr_v;
      default:        res_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      zero   <= 1'b1;
    end else begin
      result <= res_nxt;
      zero   <= (res_nxt == '0);
    end
  end

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst) zero == (result == '0)); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (result == '0 && zero)); // R10
  AST_UNUSED_OP: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(op_sel) > 4'd6) |-> result == '0); // R8
  AST_SUB_INVERSE: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(op_sel) == 4'd1) |-> (result + $past(opb)) == $past(src_a)); // R2
  AST_ADD_INVERSE: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(op_sel) == 4'd0) |-> (result - $past(opb)) == $past(src_a)); // R1
  AST_NOR_DISJOINT: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(op_sel) == 4'd4) |-> (result & ($past(src_a) | $past(opb))) == '0); // R4
  AST_SLL_LOW_FILL: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(op_sel) == 4'd5) |-> (result & ((ONE << $past(shamt)) - ONE)) == '0); // R5
  AST_SRL_HIGH_FILL: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(op_sel) == 4'd6) |-> (result & ~({DATA_W{1'b1}} >> $past(shamt))) == '0); // R6
  AST_IMM_SIGN_COPY: assert property (@(posedge clk) disable iff (rst) use_imm |-> (opb[DATA_W-1:IMM_W] == {(DATA_W-IMM_W){imm16[IMM_W-1]}})); // R7
endmodule

// File: tb/test_alu_core.sv
`timescale 1ns/1ps
module test_alu_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_sel = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [15:0] imm16 = '0;
  logic        use_imm = 1'b0;
  logic [4:0]  shamt = '0;
  logic [31:0] result;
  logic        zero;
  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  alu_core i_alu_core (
    .clk(clk), .rst(rst), .op_sel(op_sel), .src_a(src_a), .src_b(src_b),
    .imm16(imm16), .use_imm(use_imm), .shamt(shamt), .result(result), .zero(zero));

  // fields: req(4) op(4) a(32) b(32) imm(16) use_imm(1) shamt(5) expected(32)
  localparam int NV = 18;
  localparam logic [125:0] VEC [NV] = '{
    {4'd1, 4'd0, 32'h0000_0005, 32'h0000_0007, 16'h0000, 1'b0, 5'd0,  32'h0000_000C}, // R1
    {4'd1, 4'd0, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 1'b0, 5'd0,  32'h0000_0000}, // R1 wrap
    {4'd2, 4'd1, 32'h0000_000A, 32'h0000_0003, 16'h0000, 1'b0, 5'd0,  32'h0000_0007}, // R2
    {4'd2, 4'd1, 32'h0000_0000, 32'h0000_0001, 16'h0000, 1'b0, 5'd0,  32'hFFFF_FFFF}, // R2 wrap
    {4'd3, 4'd2, 32'hF0F0_F0F0, 32'hFF00_FF00, 16'h0000, 1'b0, 5'd0,  32'hF000_F000}, // R3 and
    {4'd3, 4'd3, 32'hF0F0_F0F0, 32'h0F0F_0000, 16'h0000, 1'b0, 5'd0,  32'hFFFF_F0F0}, // R3 or
    {4'd4, 4'd4, 32'h1234_5678, 32'h0000_0000, 16'h0000, 1'b0, 5'd0,  32'hEDCB_A987}, // R4 not
    {4'd4, 4'd4, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 16'h0000, 1'b0, 5'd0,  32'h0000_0000}, // R4
    {4'd5, 4'd5, 32'h0000_0003, 32'hFFFF_FFFF, 16'h0000, 1'b0, 5'd4,  32'h0000_0030}, // R5
    {4'd5, 4'd5, 32'h8000_0001, 32'h0000_0000, 16'h0000, 1'b0, 5'd31, 32'h8000_0000}, // R5
    {4'd6, 4'd6, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0000, 1'b0, 5'd31, 32'h0000_0001}, // R6
    {4'd6, 4'd6, 32'hF000_0000, 32'h0000_0000, 16'h0000, 1'b0, 5'd4,  32'h0F00_0000}, // R6
    {4'd7, 4'd0, 32'h0000_0064, 32'h0000_0005, 16'hFFFF, 1'b1, 5'd0,  32'h0000_0063}, // R7 -1
    {4'd7, 4'd0, 32'h0000_0010, 32'hFFFF_FFFF, 16'h7FFF, 1'b1, 5'd0,  32'h0000_800F}, // R7
    {4'd7, 4'd0, 32'h0000_0000, 32'h0000_0000, 16'h8000, 1'b1, 5'd0,  32'hFFFF_8000}, // R7
    {4'd7, 4'd1, 32'h0000_0005, 32'h0000_0000, 16'hFFFB, 1'b1, 5'd0,  32'h0000_000A}, // R7 sub
    {4'd8, 4'd7, 32'h0000_0005, 32'h0000_0005, 16'h0000, 1'b0, 5'd0,  32'h0000_0000}, // R8
    {4'd8, 4'd15, 32'hFFFF_FFFF, 32'h1234_5678, 16'h1111, 1'b1, 5'd3, 32'h0000_0000}  // R8
  };

  task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s result actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s flag actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R10 reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk32("R10 reset", result, 32'h0);
    chk1("R10 reset", zero, 1'b1);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [31:0] exp;
      string tag;
      {op_sel, src_a, src_b, imm16, use_imm, shamt} = VEC[i][121:32];
      exp = VEC[i][31:0];
      tag = $sformatf("R%0d vec%0d", VEC[i][125:122], i);
      @(posedge clk);
      @(negedge clk);
      chk32(tag, result, exp);
      chk1({tag, " R9"}, zero, (exp == 32'h0));
    end

    // R10 latency: new inputs are not visible until the next edge
    op_sel = 4'd0; src_a = 32'h0000_0100; src_b = 32'h0000_0023; use_imm = 1'b0;
    @(posedge clk); @(negedge clk);
    chk32("R10 load", result, 32'h0000_0123);
    src_a = 32'h0000_0200;
    #2;
    chk32("R10 hold", result, 32'h0000_0123);
    @(posedge clk); @(negedge clk);
    chk32("R10 update", result, 32'h0000_0223);

    // R10 reset mid-stream clears result and sets flag
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk32("R10 rst mid", result, 32'h0);
    chk1("R10 rst mid", zero, 1'b1);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk32("R10 after rst", result, 32'h0000_0223);
    chk1("R9 after rst", zero, 1'b0);

    // R7 with use_imm low, src_b path wins over imm16
    op_sel = 4'd0; src_a = 32'h1; src_b = 32'h2; imm16 = 16'h8000; use_imm = 1'b0;
    @(posedge clk); @(negedge clk);
    chk32("R7 reg path", result, 32'h3);

    // R5 shift by zero passes the source
    op_sel = 4'd5; src_a = 32'hDEAD_BEEF; shamt = 5'd0;
    @(posedge clk); @(negedge clk);
    chk32("R5 by zero", result, 32'hDEAD_BEEF);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule